// File: doc/BRIEF.md
# Pipeline Hazard Interlock Unit

This block decides, every cycle, whether a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) must hold its front end, insert a bubble, discard a wrongly fetched instruction, or steer operands onto bypass paths. It reads the register fields and the load, branch and write flags of the instructions in decode, execute, memory and writeback. It also reads a branch-taken signal and a prediction-correct signal. All of its outputs are combinational functions of those fields and a registered mode bit.

The mode bit selects between two operating styles. In the interlocked style, values pass only through the register file, and a branch resolves at the end of execute. In the bypassed style, results are forwarded from the memory and writeback stages, only a load feeding the very next instruction costs a stall, and a branch resolves at the end of decode. The register file is taken to write in the first half of a cycle and read in the second half, so a producer in writeback never blocks decode.

Top module: `hazard_interlock`

## Requirements
- R1: The mode input is captured on each rising clock edge and reset clears it to interlocked (0). Outputs follow the captured value, so a change of the mode input first takes effect after the next clock edge.
- R2: In interlocked mode, a used decode source that equals the destination of a writing instruction in execute or in memory raises stallFront and bubbleEx. A match only with the writeback destination causes no stall.
- R3: Register 0 never creates a dependence: not as a decode source, not as a destination, and not as a forwarding match.
- R4: In interlocked mode, a branch in execute with brTaken=1 and predOk=0 raises flushFd and bubbleEx, and keeps stallFront low even when decode has a data hazard.
- R5: In bypass mode, stallFront and bubbleEx rise only when a load in execute writes a register that decode uses. A match with a non-load in execute causes no stall.
- R6: In bypass mode, a branch in decode with brTaken=1 and predOk=0 raises flushFd with bubbleEx low. If that branch is held by a load-use stall, flushFd stays low.
- R7: With predOk=1, flushFd stays low in both modes.
- R8: Forwarding selects use code 00 for the register file, 01 for the memory-stage result and 10 for the writeback result. When both later stages match an execute source, 01 wins. In interlocked mode, both selects are 00.
- R9: A decode source whose use flag is low, such as an unused second operand, never causes a stall. A store's data register counts once its use flag is set.
- R10: stallFront and flushFd are never high together, and stallFront always comes with bubbleEx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bypassMode | input | 1 | 1 = bypassed style, 0 = interlocked style |
| dRs1 | input | 5 | First source register of decode |
| dRs2 | input | 5 | Second source (or store data) register of decode |
| dUseRs1 | input | 1 | Decode reads dRs1 |
| dUseRs2 | input | 1 | Decode reads dRs2 |
| dIsBranch | input | 1 | Decode holds a branch |
| xRs1 | input | 5 | First source register of execute |
| xRs2 | input | 5 | Second source register of execute |
| xRd | input | 5 | Destination register of execute |
| xRegWr | input | 1 | Execute instruction writes xRd |
| xIsLoad | input | 1 | Execute holds a load |
| xIsBranch | input | 1 | Execute holds a branch |
| mRd | input | 5 | Destination register of memory stage |
| mRegWr | input | 1 | Memory-stage instruction writes mRd |
| wRd | input | 5 | Destination register of writeback |
| wRegWr | input | 1 | Writeback instruction writes wRd |
| brTaken | input | 1 | The resolving branch is taken |
| predOk | input | 1 | The resolving branch was predicted correctly |
| stallFront | output | 1 | Hold PC and fetch/decode register |
| bubbleEx | output | 1 | Load a no-op into decode/execute |
| flushFd | output | 1 | Load a no-op into fetch/decode |
| fwdSelA | output | 2 | Operand A select for execute |
| fwdSelB | output | 2 | Operand B select for execute |

## Verification
Stall, bubble, flush and forwarding outputs respond within the same cycle to the stage fields, with no register in between. The mode bit, by contrast, passes through one flop and applies only after the next rising edge. The bench changes all inputs on the falling edge and samples 1 ns after the following rising edge. At that point the captured mode matches the driven one and the combinational outputs have settled. One directed check samples before that edge to show the old mode still in force.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_e;

  // strobes from control toward the compare datapath
  typedef struct packed {
    logic fwdEn;
  } dpCtrl_t;

  // pipeline steering decisions
  typedef struct packed {
    logic stall;
    logic bubble;
    logic flush;
  } steer_t;
endpackage

// File: rtl/hz_compare.sv
module hz_compare
  import hz_pkg::*;
#(
  parameter int REG_BITS = 5,
  parameter int NUM_SRC  = 2
) (
  input  logic [REG_BITS-1:0] decSrc [NUM_SRC],
  input  logic                decUse [NUM_SRC],
  input  logic [REG_BITS-1:0] exSrc  [NUM_SRC],
  input  logic [REG_BITS-1:0] exDst,
  input  logic                exWr,
  input  logic [REG_BITS-1:0] memDst,
  input  logic                memWr,
  input  logic [REG_BITS-1:0] wbDst,
  input  logic                wbWr,
  input  dpCtrl_t             ctrl,
  output logic                hitEx,
  output logic                hitMem,
  output fwd_e                fwdSel [NUM_SRC]
);
  localparam logic [REG_BITS-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0] srcHitEx;
  logic [NUM_SRC-1:0] srcHitMem;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic liveDec;
    logic liveEx;
    assign liveDec      = decUse[s] && (decSrc[s] != ZERO_REG);
    assign srcHitEx[s]  = liveDec && exWr  && (exDst  == decSrc[s]);
    assign srcHitMem[s] = liveDec && memWr && (memDst == decSrc[s]);
    assign liveEx       = ctrl.fwdEn && (exSrc[s] != ZERO_REG);

    always_comb begin
      if (liveEx && memWr && (memDst == exSrc[s])) begin
        fwdSel[s] = FWD_MEM;
      end else if (liveEx && wbWr && (wbDst == exSrc[s])) begin
        fwdSel[s] = FWD_WB;
      end else begin
        fwdSel[s] = FWD_RF;
      end
    end
  end

  assign hitEx  = |srcHitEx;
  assign hitMem = |srcHitMem;
endmodule

// File: rtl/hz_control.sv
module hz_control
  import hz_pkg::*;
(
  input  logic    modeBypass,
  input  logic    hitEx,
  input  logic    hitMem,
  input  logic    exIsLoad,
  input  logic    decIsBranch,
  input  logic    exIsBranch,
  input  logic    brTaken,
  input  logic    predOk,
  output dpCtrl_t ctrl,
  output steer_t  steer
);
  logic mispredict;
  logic loadUse;
  logic redirectEx;

  assign mispredict = brTaken && !predOk;
  assign loadUse    = hitEx && exIsLoad;
  assign redirectEx = exIsBranch && mispredict;

  always_comb begin
    ctrl.fwdEn = modeBypass;
    if (modeBypass) begin
      steer.stall  = loadUse;
      steer.bubble = loadUse;
      steer.flush  = decIsBranch && mispredict && !loadUse;
    end else begin
      steer.stall  = (hitEx || hitMem) && !redirectEx;
      steer.bubble = steer.stall || redirectEx;
      steer.flush  = redirectEx;
    end
  end
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import hz_pkg::*;
#(
  parameter int REG_BITS = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bypassMode,
  input  logic [REG_BITS-1:0] dRs1,
  input  logic [REG_BITS-1:0] dRs2,
  input  logic                dUseRs1,
  input  logic                dUseRs2,
  input  logic                dIsBranch,
  input  logic [REG_BITS-1:0] xRs1,
  input  logic [REG_BITS-1:0] xRs2,
  input  logic [REG_BITS-1:0] xRd,
  input  logic                xRegWr,
  input  logic                xIsLoad,
  input  logic                xIsBranch,
  input  logic [REG_BITS-1:0] mRd,
  input  logic                mRegWr,
  input  logic [REG_BITS-1:0] wRd,
  input  logic                wRegWr,
  input  logic                brTaken,
  input  logic                predOk,
  output logic                stallFront,
  output logic                bubbleEx,
  output logic                flushFd,
  output logic [1:0]          fwdSelA,
  output logic [1:0]          fwdSelB
);
  localparam int NUM_SRC = 2;

  logic                modeQ;
  logic [REG_BITS-1:0] decSrc [NUM_SRC];
  logic                decUse [NUM_SRC];
  logic [REG_BITS-1:0] exSrc  [NUM_SRC];
  fwd_e                fwdSel [NUM_SRC];
  logic                hitEx;
  logic                hitMem;
  dpCtrl_t             ctrl;
  steer_t              steer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= 1'b0;
    else       modeQ <= bypassMode;
  end

  assign decSrc[0] = dRs1;
  assign decSrc[1] = dRs2;
  assign decUse[0] = dUseRs1;
  assign decUse[1] = dUseRs2;
  assign exSrc[0]  = xRs1;
  assign exSrc[1]  = xRs2;

  hz_compare #(.REG_BITS(REG_BITS), .NUM_SRC(NUM_SRC)) i_compare (
    .decSrc (decSrc),
    .decUse (decUse),
    .exSrc  (exSrc),
    .exDst  (xRd),
    .exWr   (xRegWr),
    .memDst (mRd),
    .memWr  (mRegWr),
    .wbDst  (wRd),
    .wbWr   (wRegWr),
    .ctrl   (ctrl),
    .hitEx  (hitEx),
    .hitMem (hitMem),
    .fwdSel (fwdSel)
  );

  hz_control i_control (
    .modeBypass  (modeQ),
    .hitEx       (hitEx),
    .hitMem      (hitMem),
    .exIsLoad    (xIsLoad),
    .decIsBranch (dIsBranch),
    .exIsBranch  (xIsBranch),
    .brTaken     (brTaken),
    .predOk      (predOk),
    .ctrl        (ctrl),
    .steer       (steer)
  );

  assign stallFront = steer.stall;
  assign bubbleEx   = steer.bubble;
  assign flushFd    = steer.flush;
  assign fwdSelA    = fwdSel[0];
  assign fwdSelB    = fwdSel[1];
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int REG_BITS = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                modeQ,
  input logic [REG_BITS-1:0] dRs1,
  input logic [REG_BITS-1:0] dRs2,
  input logic                dUseRs1,
  input logic                dUseRs2,
  input logic                xIsLoad,
  input logic                predOk,
  input logic                stallFront,
  input logic                bubbleEx,
  input logic                flushFd,
  input logic [1:0]          fwdSelA,
  input logic [1:0]          fwdSelB
);
  a_r10_no_stall_and_flush: assert property (@(posedge clk) disable iff (!rstN)
    !(stallFront && flushFd));

  a_r10_stall_bubbles: assert property (@(posedge clk) disable iff (!rstN)
    stallFront |-> bubbleEx);

  a_r7_predicted_no_flush: assert property (@(posedge clk) disable iff (!rstN)
    predOk |-> !flushFd);

  a_r8_interlocked_no_bypass: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ |-> (fwdSelA == 2'd0 && fwdSelB == 2'd0));

  a_r3_r9_no_live_source: assert property (@(posedge clk) disable iff (!rstN)
    ((!dUseRs1 || dRs1 == '0) && (!dUseRs2 || dRs2 == '0)) |-> !stallFront);

  a_r5_bypass_load_only: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ && !xIsLoad) |-> !stallFront);
endmodule

bind hazard_interlock hz_checker #(.REG_BITS(REG_BITS)) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .modeQ      (modeQ),
  .dRs1       (dRs1),
  .dRs2       (dRs2),
  .dUseRs1    (dUseRs1),
  .dUseRs2    (dUseRs2),
  .xIsLoad    (xIsLoad),
  .predOk     (predOk),
  .stallFront (stallFront),
  .bubbleEx   (bubbleEx),
  .flushFd    (flushFd),
  .fwdSelA    (fwdSelA),
  .fwdSelB    (fwdSelB)
);

// File: tb/test_hazard_interlock.sv
`timescale 1ns/1ps
module test_hazard_interlock;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bypassMode = 1'b0;
  logic [4:0] dRs1 = '0, dRs2 = '0, xRs1 = '0, xRs2 = '0, xRd = '0, mRd = '0, wRd = '0;
  logic dUseRs1 = 1'b0, dUseRs2 = 1'b0, dIsBranch = 1'b0;
  logic xRegWr = 1'b0, xIsLoad = 1'b0, xIsBranch = 1'b0, mRegWr = 1'b0, wRegWr = 1'b0;
  logic brTaken = 1'b0, predOk = 1'b0;
  logic stallFront, bubbleEx, flushFd;
  logic [1:0] fwdSelA, fwdSelB;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  hazard_interlock i_hazard_interlock (
    .clk(clk), .rstN(rstN), .bypassMode(bypassMode),
    .dRs1(dRs1), .dRs2(dRs2), .dUseRs1(dUseRs1), .dUseRs2(dUseRs2), .dIsBranch(dIsBranch),
    .xRs1(xRs1), .xRs2(xRs2), .xRd(xRd), .xRegWr(xRegWr), .xIsLoad(xIsLoad), .xIsBranch(xIsBranch),
    .mRd(mRd), .mRegWr(mRegWr), .wRd(wRd), .wRegWr(wRegWr),
    .brTaken(brTaken), .predOk(predOk),
    .stallFront(stallFront), .bubbleEx(bubbleEx), .flushFd(flushFd),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       mode;
    logic [4:0] dR1; logic [4:0] dR2; logic dU1; logic dU2; logic dBr;
    logic [4:0] xR1; logic [4:0] xR2; logic [4:0] xD; logic xW; logic xL; logic xBr;
    logic [4:0] mD; logic mW;
    logic [4:0] wD; logic wW;
    logic tk; logic pok;
    logic eSt; logic eBu; logic eFl; logic [1:0] eA; logic [1:0] eB;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{2,0, 3,4,1,1,0, 0,0,3,1,0,0, 0,0, 0,0, 0,0, 1,1,0,0,0}, // R2 producer in execute
    '{2,0, 3,4,1,1,0, 0,0,9,1,0,0, 4,1, 0,0, 0,0, 1,1,0,0,0}, // R2 producer in memory
    '{2,0, 3,4,1,1,0, 0,0,9,1,0,0, 8,1, 3,1, 0,0, 0,0,0,0,0}, // R2 writeback only: no stall
    '{3,0, 0,0,1,1,0, 0,0,0,1,0,0, 0,1, 0,0, 0,0, 0,0,0,0,0}, // R3 register 0
    '{9,0, 5,6,0,1,0, 0,0,5,1,0,0, 0,0, 0,0, 0,0, 0,0,0,0,0}, // R9 unused source
    '{4,0, 3,0,1,0,0, 0,0,0,0,0,1, 3,1, 0,0, 1,0, 0,1,1,0,0}, // R4 R10 flush beats hazard
    '{7,0, 3,0,1,0,0, 0,0,0,0,0,1, 3,1, 0,0, 1,1, 1,1,0,0,0}, // R7 predicted: hazard stalls
    '{5,1, 7,0,1,0,0, 0,0,7,1,1,0, 0,0, 0,0, 0,0, 1,1,0,0,0}, // R5 load-use
    '{5,1, 7,0,1,0,0, 0,0,7,1,0,0, 0,0, 0,0, 0,0, 0,0,0,0,0}, // R5 ALU match forwarded
    '{6,1, 0,0,0,0,1, 0,0,0,0,0,0, 0,0, 0,0, 1,0, 0,0,1,0,0}, // R6 decode branch flush
    '{6,1, 7,0,1,0,1, 0,0,7,1,1,0, 0,0, 0,0, 1,0, 1,1,0,0,0}, // R6 R10 held branch no flush
    '{7,1, 0,0,0,0,1, 0,0,0,0,0,0, 0,0, 0,0, 1,1, 0,0,0,0,0}, // R7 bypass predicted
    '{8,1, 0,0,0,0,0, 5,6,0,0,0,0, 5,1, 6,1, 0,0, 0,0,0,1,2}, // R8 mem and wb paths
    '{8,1, 0,0,0,0,0, 5,5,0,0,0,0, 5,1, 5,1, 0,0, 0,0,0,1,1}, // R8 memory priority
    '{8,0, 0,0,0,0,0, 5,5,0,0,0,0, 5,1, 5,1, 0,0, 0,0,0,0,0}, // R8 interlocked selects 00
    '{3,1, 0,0,0,0,0, 0,0,0,0,0,0, 0,1, 0,1, 0,0, 0,0,0,0,0}, // R3 no forward of reg 0
    '{8,1, 0,0,0,0,0, 5,0,0,0,0,0, 5,0, 5,1, 0,0, 0,0,0,2,0}  // R8 non-writing memory
  };

  task automatic check(input int req, input logic [6:0] act, input logic [6:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL R%0d actual=%b expected=%b (stall,bubble,flush,selA,selB)", req, act, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {stallFront, bubbleEx, flushFd, fwdSelA, fwdSelB};
  endfunction

  task automatic apply(input vec_t v);
    bypassMode = v.mode;
    dRs1 = v.dR1; dRs2 = v.dR2; dUseRs1 = v.dU1; dUseRs2 = v.dU2; dIsBranch = v.dBr;
    xRs1 = v.xR1; xRs2 = v.xR2; xRd = v.xD; xRegWr = v.xW; xIsLoad = v.xL; xIsBranch = v.xBr;
    mRd = v.mD; mRegWr = v.mW; wRd = v.wD; wRegWr = v.wW;
    brTaken = v.tk; predOk = v.pok;
  endtask

  initial begin : watchdog
    #200000;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : stimulus
    // R1: in reset the mode is interlocked even with bypassMode high
    apply('{1,1, 3,0,1,0,0, 0,0,3,1,0,0, 0,0, 0,0, 0,0, 0,0,0,0,0});
    repeat (2) @(posedge clk);
    #1 check(1, outs(), 7'b1100000);
    @(negedge clk) rstN = 1'b1;
    bypassMode = 1'b0;
    @(posedge clk);
    @(negedge clk) bypassMode = 1'b1;
    #1 check(1, outs(), 7'b1100000); // R1 old mode before edge
    @(posedge clk);
    #1 check(1, outs(), 7'b0000000); // R1 new mode after edge

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk) apply(VECS[i]);
      @(posedge clk);
      #1 check(int'(VECS[i].req), outs(),
               {VECS[i].eSt, VECS[i].eBu, VECS[i].eFl, VECS[i].eA, VECS[i].eB});
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule